// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides which clock domains of a small processor-based system may run. Software selects a sleep depth by writing a two-bit mode command. The block then drives enables for the processor clock, the memory and internal-bus clock, the PLL domain that feeds the peripheral clock divider, and the oscillator, plus one gated clock enable per peripheral.

A light sleep stops only the processor and bus domains, so peripherals keep counting and can raise an interrupt to end it. A deep sleep turns off every internal enable and the oscillator. Only reset, or an enabled wake line that can be sensed without a clock, ends it. On leaving deep sleep the oscillator runs alone for a programmable settling count before the internal clocks come back. The per-peripheral enable mask works separately from the sleep depth, so unused peripherals can stay gated while the system runs.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Reset (rstN low, asynchronous) gives the run state, with cpuClkEn, busClkEn, pllClkEn and oscEn all 1, every perEnRd bit and every perClkEn bit 1, modeRd equal to 0, wake mask 0, and the settling count at its parameter default.
- R2: In run, a mode write with modeWrData bit 0 set and bit 1 clear enters light sleep after that clock edge. There cpuClkEn and busClkEn are 0, pllClkEn and oscEn stay 1, and perClkEn equals perEnRd.
- R3: In light sleep, any bit of irqIn high at a clock edge returns the block to run after that edge, with all four domain enables 1.
- R4: In run, a mode write with modeWrData bit 1 set enters deep sleep after that edge, whatever bit 0 holds. There cpuClkEn, busClkEn, pllClkEn, oscEn and every perClkEn bit are 0.
- R5: In deep sleep irqIn has no effect. The block leaves only when asyncWake ANDed with the wake mask is nonzero, after a two-flop synchronizer.
- R6: perClkEn[i] is 1 only when perEnRd[i] is 1 and the state is run or light sleep. perEnWrEn loads perEnWrData into the mask in any state.
- R7: modeRd reads 2'b01 in light sleep and 2'b10 in deep sleep and settling, and reads 0 once run is entered again.
- R8: When the wake condition is seen, oscEn rises while cpuClkEn, busClkEn and pllClkEn stay 0 for exactly S+1 cycles, S being the settling count register. Then the block enters run.
- R9: Mode writes made outside run, or with both mode bits clear, leave the state and modeRd unchanged.
- R10: wakeMaskWrEn and startupWrEn load the wake mask and the settling count in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWrEn | input | 1 | Mode command write strobe |
| modeWrData | input | 2 | Bit 0 light sleep, bit 1 deep sleep |
| perEnWrEn | input | 1 | Peripheral enable mask write strobe |
| perEnWrData | input | NUM_PERIPH | New peripheral enable mask |
| wakeMaskWrEn | input | 1 | Wake mask write strobe |
| wakeMaskWrData | input | NUM_WAKE | New wake mask |
| startupWrEn | input | 1 | Settling count write strobe |
| startupWrData | input | CNT_W | New settling count |
| irqIn | input | NUM_IRQ | Interrupt request lines |
| asyncWake | input | NUM_WAKE | Clockless wake lines, asynchronous |
| cpuClkEn | output | 1 | Processor clock enable |
| busClkEn | output | 1 | Memory and internal-bus clock enable |
| pllClkEn | output | 1 | PLL domain enable |
| oscEn | output | 1 | Oscillator enable |
| perClkEn | output | NUM_PERIPH | Per-peripheral clock enables |
| modeRd | output | 2 | Mode bits read-back |
| perEnRd | output | NUM_PERIPH | Peripheral enable mask read-back |

## Verification
The assertions assume that wake lines stay high until the block has left deep sleep. They also assume that interrupts in light sleep are level signals sampled at a clock edge. The stimulus drives every input at the falling edge and holds asyncWake high until cpuClkEn returns, then drops it. Mode writes made in a sleep state are deliberate, to exercise R9, and are always one-cycle strobes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_IDLE    = 2'd1,
    ST_PDOWN   = 2'd2,
    ST_OSCWAIT = 2'd3
  } pwrState_t;

  typedef struct packed {
    logic setIdle;
    logic setPdown;
    logic clrMode;
    logic loadCnt;
    logic decCnt;
  } ctrlStrobe_t;
endpackage

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int NUM_PERIPH  = 4,
  parameter int NUM_WAKE    = 2,
  parameter int CNT_W       = 8,
  parameter int STARTUP_RST = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic                  perEnWrEn,
  input  logic [NUM_PERIPH-1:0] perEnWrData,
  input  logic                  wakeMaskWrEn,
  input  logic [NUM_WAKE-1:0]   wakeMaskWrData,
  input  logic                  startupWrEn,
  input  logic [CNT_W-1:0]      startupWrData,
  input  logic [NUM_WAKE-1:0]   asyncWake,
  output logic [1:0]            modeBits,
  output logic [NUM_PERIPH-1:0] perEnReg,
  output logic                  wakeHit,
  output logic                  cntZero
);
  localparam logic [CNT_W-1:0] StartupInit = CNT_W'(STARTUP_RST);

  logic [NUM_WAKE-1:0] wakeMask;
  logic [NUM_WAKE-1:0] wakeSync;
  logic [CNT_W-1:0]    startupCnt;
  logic [CNT_W-1:0]    oscCnt;

  // Two-flop synchronizer per clockless wake line
  for (genvar w = 0; w < NUM_WAKE; w++) begin : g_wakeSync
    logic meta;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta        <= 1'b0;
        wakeSync[w] <= 1'b0;
      end else begin
        meta        <= asyncWake[w];
        wakeSync[w] <= meta;
      end
    end
  end

  assign wakeHit = |(wakeSync & wakeMask);
  assign cntZero = (oscCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeBits <= 2'b00;
    end else if (strobe.clrMode) begin
      modeBits <= 2'b00;
    end else if (strobe.setPdown) begin
      modeBits <= 2'b10;
    end else if (strobe.setIdle) begin
      modeBits <= 2'b01;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perEnReg   <= '1;
      wakeMask   <= '0;
      startupCnt <= StartupInit;
    end else begin
      if (perEnWrEn)    perEnReg   <= perEnWrData;
      if (wakeMaskWrEn) wakeMask   <= wakeMaskWrData;
      if (startupWrEn)  startupCnt <= startupWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscCnt <= '0;
    end else if (strobe.loadCnt) begin
      oscCnt <= startupCnt;
    end else if (strobe.decCnt && !cntZero) begin
      oscCnt <= oscCnt - 1'b1;
    end
  end

  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(modeBits)); // R7
  AST_CNT_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCnt |=> oscCnt == $past(startupCnt)); // R8
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeWrEn,
  input  logic [1:0]  modeWrData,
  input  logic        irqAny,
  input  logic        wakeHit,
  input  logic        cntZero,
  output pwrState_t   state,
  output ctrlStrobe_t strobe
);
  pwrState_t stateNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    case (state)
      ST_RUN: begin
        if (modeWrEn && modeWrData[1]) begin
          stateNxt        = ST_PDOWN;
          strobe.setPdown = 1'b1;
        end else if (modeWrEn && modeWrData[0]) begin
          stateNxt       = ST_IDLE;
          strobe.setIdle = 1'b1;
        end
      end
      ST_IDLE: begin
        if (irqAny) begin
          stateNxt       = ST_RUN;
          strobe.clrMode = 1'b1;
        end
      end
      ST_PDOWN: begin
        if (wakeHit) begin
          stateNxt       = ST_OSCWAIT;
          strobe.loadCnt = 1'b1;
        end
      end
      ST_OSCWAIT: begin
        if (cntZero) begin
          stateNxt       = ST_RUN;
          strobe.clrMode = 1'b1;
        end else begin
          strobe.decCnt = 1'b1;
        end
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && irqAny) |=> state == ST_RUN); // R3
  AST_PDOWN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PDOWN && !wakeHit) |=> state == ST_PDOWN); // R5
  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OSCWAIT && !cntZero) |=> state == ST_OSCWAIT); // R8
  AST_SLEEP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !irqAny) |=> state == ST_IDLE); // R9
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_PERIPH  = 4,
  parameter int NUM_WAKE    = 2,
  parameter int NUM_IRQ     = 8,
  parameter int CNT_W       = 8,
  parameter int STARTUP_RST = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  modeWrEn,
  input  logic [1:0]            modeWrData,
  input  logic                  perEnWrEn,
  input  logic [NUM_PERIPH-1:0] perEnWrData,
  input  logic                  wakeMaskWrEn,
  input  logic [NUM_WAKE-1:0]   wakeMaskWrData,
  input  logic                  startupWrEn,
  input  logic [CNT_W-1:0]      startupWrData,
  input  logic [NUM_IRQ-1:0]    irqIn,
  input  logic [NUM_WAKE-1:0]   asyncWake,
  output logic                  cpuClkEn,
  output logic                  busClkEn,
  output logic                  pllClkEn,
  output logic                  oscEn,
  output logic [NUM_PERIPH-1:0] perClkEn,
  output logic [1:0]            modeRd,
  output logic [NUM_PERIPH-1:0] perEnRd
);
  pwrState_t   state;
  ctrlStrobe_t strobe;
  logic        wakeHit;
  logic        cntZero;
  logic        perDomainOn;

  pmc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeWrEn   (modeWrEn),
    .modeWrData (modeWrData),
    .irqAny     (|irqIn),
    .wakeHit    (wakeHit),
    .cntZero    (cntZero),
    .state      (state),
    .strobe     (strobe)
  );

  pmc_datapath #(
    .NUM_PERIPH  (NUM_PERIPH),
    .NUM_WAKE    (NUM_WAKE),
    .CNT_W       (CNT_W),
    .STARTUP_RST (STARTUP_RST)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .perEnWrEn      (perEnWrEn),
    .perEnWrData    (perEnWrData),
    .wakeMaskWrEn   (wakeMaskWrEn),
    .wakeMaskWrData (wakeMaskWrData),
    .startupWrEn    (startupWrEn),
    .startupWrData  (startupWrData),
    .asyncWake      (asyncWake),
    .modeBits       (modeRd),
    .perEnReg       (perEnRd),
    .wakeHit        (wakeHit),
    .cntZero        (cntZero)
  );

  assign perDomainOn = (state == ST_RUN) || (state == ST_IDLE);
  assign cpuClkEn    = (state == ST_RUN);
  assign busClkEn    = (state == ST_RUN);
  assign pllClkEn    = perDomainOn;
  assign oscEn       = (state != ST_PDOWN);
  assign perClkEn    = perEnRd & {NUM_PERIPH{perDomainOn}};

  AST_PDOWN_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (modeRd == 2'b10 && !oscEn) |-> (perClkEn == '0 && !pllClkEn && !cpuClkEn && !busClkEn)); // R4
  AST_IDLE_PLL_ON: assert property (@(posedge clk) disable iff (!rstN)
    (modeRd == 2'b01) |-> (pllClkEn && oscEn && !cpuClkEn && perClkEn == perEnRd)); // R2
  AST_PER_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (perClkEn & ~perEnRd) == '0); // R6
  AST_MODE_SELFCLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuClkEn) |-> modeRd == 2'b00); // R7
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  localparam int NP = 4;
  localparam int NW = 2;
  localparam int NI = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modeWrEn = 1'b0;
  logic [1:0]    modeWrData = '0;
  logic          perEnWrEn = 1'b0;
  logic [NP-1:0] perEnWrData = '0;
  logic          wakeMaskWrEn = 1'b0;
  logic [NW-1:0] wakeMaskWrData = '0;
  logic          startupWrEn = 1'b0;
  logic [CW-1:0] startupWrData = '0;
  logic [NI-1:0] irqIn = '0;
  logic [NW-1:0] asyncWake = '0;
  logic          cpuClkEn, busClkEn, pllClkEn, oscEn;
  logic [NP-1:0] perClkEn, perEnRd;
  logic [1:0]    modeRd;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.NUM_PERIPH(NP), .NUM_WAKE(NW), .NUM_IRQ(NI), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .perEnWrEn(perEnWrEn), .perEnWrData(perEnWrData),
    .wakeMaskWrEn(wakeMaskWrEn), .wakeMaskWrData(wakeMaskWrData),
    .startupWrEn(startupWrEn), .startupWrData(startupWrData),
    .irqIn(irqIn), .asyncWake(asyncWake),
    .cpuClkEn(cpuClkEn), .busClkEn(busClkEn), .pllClkEn(pllClkEn), .oscEn(oscEn),
    .perClkEn(perClkEn), .modeRd(modeRd), .perEnRd(perEnRd)
  );

  // vector: {wr, data[1:0], irq, exp cpu,bus,pll,osc, expPerOn, expMode[1:0], reqTag[3:0]}
  localparam int NV = 7;
  localparam logic [14:0] VECS [NV] = '{
    {1'b0, 2'b00, 1'b0, 4'b1111, 1'b1, 2'b00, 4'd1},
    {1'b1, 2'b00, 1'b0, 4'b1111, 1'b1, 2'b00, 4'd9},
    {1'b1, 2'b01, 1'b0, 4'b0011, 1'b1, 2'b01, 4'd2},
    {1'b1, 2'b10, 1'b0, 4'b0011, 1'b1, 2'b01, 4'd9},
    {1'b0, 2'b00, 1'b1, 4'b1111, 1'b1, 2'b00, 4'd3},
    {1'b1, 2'b11, 1'b0, 4'b0000, 1'b0, 2'b10, 4'd4},
    {1'b0, 2'b00, 1'b1, 4'b0000, 1'b0, 2'b10, 4'd5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeMode(input logic [1:0] d);
    modeWrEn = 1'b1; modeWrData = d;
    cycle();
    modeWrEn = 1'b0; modeWrData = '0;
  endtask

  // wake from deep sleep, return number of settling cycles seen
  task automatic wakeAndMeasure(output int settle, output int badPll);
    int guard;
    asyncWake = 2'b01;
    settle = 0; badPll = 0; guard = 0;
    while (!oscEn && guard < 20) begin cycle(); guard++; end
    while (!cpuClkEn && guard < 400) begin
      if (oscEn && !busClkEn) settle++;
      if (pllClkEn) badPll++;
      cycle(); guard++;
    end
    asyncWake = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int settle, badPll;
    @(negedge clk);
    // R1 reset state while held
    check("R1", {cpuClkEn, busClkEn, pllClkEn, oscEn}, 4'b1111);
    check("R1", perClkEn, 4'hF);
    check("R1", modeRd, 2'b00);
    cycle();
    rstN = 1'b1;
    cycle();

    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      v = VECS[i];
      modeWrEn = v[14]; modeWrData = v[13:12]; irqIn = v[11] ? 8'h20 : 8'h00;
      cycle();
      modeWrEn = 1'b0; modeWrData = '0; irqIn = '0;
      check($sformatf("R%0d vec%0d en", v[3:0], i), {cpuClkEn, busClkEn, pllClkEn, oscEn}, v[10:7]);
      check($sformatf("R%0d vec%0d per", v[3:0], i), perClkEn, v[6] ? perEnRd : 4'h0);
      check($sformatf("R%0d vec%0d mode (R7)", v[3:0], i), modeRd, v[5:4]);
    end

    // R5: wake line with mask clear keeps deep sleep
    asyncWake = 2'b01;
    repeat (6) cycle();
    check("R5 masked wake", {cpuClkEn, oscEn}, 2'b00);
    asyncWake = '0;

    // R10: load mask and settling count while asleep; R8 settling length
    wakeMaskWrEn = 1'b1; wakeMaskWrData = 2'b01;
    startupWrEn = 1'b1; startupWrData = 8'd3;
    cycle();
    wakeMaskWrEn = 1'b0; startupWrEn = 1'b0;
    check("R5 still asleep", oscEn, 1'b0);
    wakeAndMeasure(settle, badPll);
    check("R8 settle S=3", settle, 4);
    check("R8 pll low while settling", badPll, 0);
    check("R7 mode cleared after deep wake", modeRd, 2'b00);
    check("R8 run after settle", {cpuClkEn, busClkEn, pllClkEn, oscEn}, 4'b1111);

    // R8 boundary: S=0 gives one settling cycle
    startupWrEn = 1'b1; startupWrData = 8'd0;
    cycle();
    startupWrEn = 1'b0;
    writeMode(2'b10);
    check("R4 deep sleep", {pllClkEn, oscEn}, 2'b00);
    wakeAndMeasure(settle, badPll);
    check("R8 settle S=0", settle, 1);

    // R6: peripheral mask in run, light sleep, deep sleep
    perEnWrEn = 1'b1; perEnWrData = 4'b0101;
    cycle();
    perEnWrEn = 1'b0;
    check("R6 run mask", perClkEn, 4'b0101);
    writeMode(2'b01);
    check("R6 idle mask", perClkEn, 4'b0101);
    perEnWrEn = 1'b1; perEnWrData = 4'b0110;
    cycle();
    perEnWrEn = 1'b0;
    check("R6 write during idle", perClkEn, 4'b0110);
    irqIn = 8'h01;
    cycle();
    irqIn = '0;
    check("R3 irq bit0 wakes", cpuClkEn, 1'b1);
    writeMode(2'b10);
    check("R6 deep mask", perClkEn, 4'b0000);
    check("R6 mask kept", perEnRd, 4'b0110);

    // R1: reset during deep sleep
    rstN = 1'b0;
    #1;
    check("R1 reset in deep sleep", {cpuClkEn, busClkEn, pllClkEn, oscEn}, 4'b1111);
    check("R1 mask restored", perEnRd, 4'hF);
    check("R1 mode cleared", modeRd, 2'b00);
    cycle();
    rstN = 1'b1;
    cycle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule